// File: doc/BRIEF.md
# Branch-Driven Program Phase Classifier

This block sorts stretches of program execution into recurring phases. Each committed branch reaches it with its address and the number of instructions retired since the branch before it. A hash of the address picks one of 32 saturating buckets, and the instruction count is added to that bucket, one branch per clock. When the running instruction total for the interval reaches a programmable length, the buckets are frozen into a snapshot and cleared for the next interval.

Each bucket in the snapshot becomes one signature bit. The bit is set when the bucket holds more than the average of all buckets. The 32-bit signature is compared against up to 16 stored signatures. If any stored signature is within a programmable Hamming distance, the interval gets that entry's index. If none is, the signature is stored in the next free entry and reported as a new phase. A power manager or other consumer reads the result on a one-cycle valid pulse, and the result stays on the outputs until the next interval closes.

Top module: `phase_sig_detector`

## Requirements
- R1: While `rst` is high, and after it falls until the first interval closes, `phase_valid`, `phase_id`, `phase_new` and `table_full` are all 0 and no history entry counts as used.
- R2: The bucket index is an XOR fold of the branch address. Index bit j is the XOR of every address bit i, with i >= 2 and (i-2) mod 5 == j. Address bits 1:0 have no effect.
- R3: Each valid branch adds `br_icount` to its bucket. A bucket saturates at 2^BKT_W-1 and never wraps.
- R4: An interval closes on the valid branch that brings the interval's instruction total to `cfg_interval_len` or beyond, and that branch is counted in the closing interval. The next interval starts with every bucket at zero and an instruction total of zero. Any excess is not carried over.
- R5: Signature bit b is 1 exactly when bucket b multiplied by 32 is greater than the sum of all 32 saturated buckets.
- R6: `phase_valid` is high for exactly one cycle, on the clock edge after the edge that accepts the closing branch.
- R7: If a used entry is within `cfg_hd_thresh` Hamming distance of the signature (distance <= threshold), `phase_id` is the lowest such index, and `phase_new` and `table_full` are 0.
- R8: On a miss with a free entry, the signature is stored at the next unused index (entries fill 0, 1, 2, ...). `phase_id` is that index, `phase_new` is 1 and `table_full` is 0.
- R9: On a miss with all 16 entries used, `table_full` is 1, `phase_new` is 0 and `phase_id` is 0, and the table is unchanged.
- R10: `phase_id`, `phase_new` and `table_full` hold their values between `phase_valid` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | 1 | A committed branch is presented this cycle |
| br_addr | input | ADDR_W | Branch address |
| br_icount | input | CNT_W | Instructions retired since the previous branch |
| cfg_interval_len | input | LEN_W | Instructions per interval |
| cfg_hd_thresh | input | HD_W | Largest Hamming distance counted as a match |
| phase_valid | output | 1 | One-cycle pulse when a result is available |
| phase_id | output | IDW | Matched or newly assigned history index |
| phase_new | output | 1 | The result created a new history entry |
| table_full | output | 1 | Miss with no free history entry |

## Verification
The bench targets these corner cases, and each one exposes a specific kind of wrong design.
- **Address folding.** Addresses whose upper bits cancel under the fold, with junk in bits 1:0, must land in the same bucket as a plain address. A hash that keeps the low bits or skips the fold would file them as a different phase.
- **Saturation.** One bucket is overfilled so that clamping changes which of the other buckets sit above the mean. A wrapping or unclamped bucket would produce a different signature.
- **Interval close.** The close must happen at exactly `>=` the length, and nothing from the closed interval may carry into the next. Off-by-one closing, or a missing clear, shows up as an early pulse or a merged signature.
- **History lookup.** Ties between several entries within the threshold check the lowest-index rule. Filling all sixteen entries checks that an overflow sets the full flag and leaves lookups intact, rather than overwriting an entry.

// File: rtl/phase_pkg.sv
package phase_pkg;
  // outcome of a history lookup
  typedef enum logic [1:0] {
    RES_HIT  = 2'd0,
    RES_NEW  = 2'd1,
    RES_FULL = 2'd2
  } match_kind_e;
endpackage

// File: rtl/phase_hash.sv
module phase_hash #(
  parameter int ADDR_W = 32,
  parameter int HB     = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [HB-1:0]     idx
);
  logic unused_low;
  assign unused_low = ^addr[1:0];

  // fold address bits above bit 1 into HB bits by XOR
  always_comb begin
    idx = '0;
    for (int i = 2; i < ADDR_W; i++) idx[(i-2) % HB] ^= addr[i];
  end
endmodule

// File: rtl/phase_accum.sv
module phase_accum #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int LEN_W  = 32,
  parameter int NBKT   = 32,
  parameter int BKT_W  = 24,
  localparam int HB    = $clog2(NBKT),
  localparam int SUM_W = BKT_W + HB
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  br_valid,
  input  logic [ADDR_W-1:0]     br_addr,
  input  logic [CNT_W-1:0]      br_icount,
  input  logic [LEN_W-1:0]      cfg_len,
  output logic                  snap_v,
  output logic [NBKT*BKT_W-1:0] snap_flat,
  output logic [SUM_W-1:0]      snap_sum
);
  localparam int AW = ((BKT_W > CNT_W) ? BKT_W : CNT_W) + 1;
  localparam logic [AW-1:0] MAXV = AW'({BKT_W{1'b1}});

  logic [HB-1:0]    hidx;
  logic [BKT_W-1:0] bkt [NBKT];
  logic [BKT_W-1:0] nxt [NBKT];
  logic [BKT_W-1:0] snap [NBKT];
  logic [SUM_W-1:0] nxt_sum;
  logic [LEN_W-1:0] icnt;
  logic [LEN_W:0]   tot;
  logic             close;

  phase_hash #(.ADDR_W(ADDR_W), .HB(HB)) u_hash (.addr(br_addr), .idx(hidx));

  assign tot   = {1'b0, icnt} + (LEN_W+1)'(br_icount);
  assign close = br_valid && (tot >= {1'b0, cfg_len});

  for (genvar b = 0; b < NBKT; b++) begin : g_bkt
    logic [AW-1:0] wide;
    assign wide = AW'(bkt[b]) + ((br_valid && hidx == HB'(b)) ? AW'(br_icount) : '0);
    assign nxt[b] = (wide > MAXV) ? {BKT_W{1'b1}} : wide[BKT_W-1:0];
    assign snap_flat[b*BKT_W +: BKT_W] = snap[b];
  end

  always_comb begin
    nxt_sum = '0;
    for (int b = 0; b < NBKT; b++) nxt_sum += SUM_W'(nxt[b]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      icnt     <= '0;
      snap_v   <= 1'b0;
      snap_sum <= '0;
      for (int b = 0; b < NBKT; b++) begin
        bkt[b]  <= '0;
        snap[b] <= '0;
      end
    end else begin
      snap_v <= close;
      if (close) begin
        icnt     <= '0;
        snap_sum <= nxt_sum;
        for (int b = 0; b < NBKT; b++) begin
          snap[b] <= nxt[b];
          bkt[b]  <= '0;
        end
      end else if (br_valid) begin
        icnt <= tot[LEN_W-1:0];
        for (int b = 0; b < NBKT; b++) bkt[b] <= nxt[b];
      end
    end
  end

  // R3: within an interval a bucket never decreases (no wrap)
  assert_no_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    !close |=> (bkt[0] >= $past(bkt[0])));
endmodule

// File: rtl/phase_match.sv
module phase_match
  import phase_pkg::*;
#(
  parameter int NBKT   = 32,
  parameter int BKT_W  = 24,
  parameter int NHIST  = 16,
  localparam int HB    = $clog2(NBKT),
  localparam int SUM_W = BKT_W + HB,
  localparam int HD_W  = $clog2(NBKT + 1),
  localparam int IDW   = $clog2(NHIST)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_v,
  input  logic [NBKT*BKT_W-1:0] snap_flat,
  input  logic [SUM_W-1:0]      snap_sum,
  input  logic [HD_W-1:0]       cfg_thresh,
  output logic                  phase_valid,
  output logic [IDW-1:0]        phase_id,
  output logic                  phase_new,
  output logic                  table_full
);
  logic [NBKT-1:0]  sig;
  logic [NBKT-1:0]  hist [NHIST];
  logic [NHIST-1:0] used;
  logic [IDW:0]     nused;
  logic             hit;
  logic [IDW-1:0]   hidx;
  logic             full;
  match_kind_e      kind;

  // bucket above mean <=> bucket*NBKT > sum (NBKT is a power of two)
  for (genvar b = 0; b < NBKT; b++) begin : g_sig
    assign sig[b] = {snap_flat[b*BKT_W +: BKT_W], {HB{1'b0}}} > snap_sum;
  end

  assign full = (nused == (IDW+1)'(NHIST));

  always_comb begin
    hit  = 1'b0;
    hidx = '0;
    for (int k = NHIST-1; k >= 0; k--) begin
      if (used[k] && ($countones(sig ^ hist[k]) <= int'(cfg_thresh))) begin
        hit  = 1'b1;
        hidx = IDW'(k);
      end
    end
    if (hit)       kind = RES_HIT;
    else if (full) kind = RES_FULL;
    else           kind = RES_NEW;
  end

  // history storage: no reset, single write port
  always_ff @(posedge clk) begin
    if (in_v && kind == RES_NEW) hist[nused[IDW-1:0]] <= sig;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      used        <= '0;
      nused       <= '0;
      phase_valid <= 1'b0;
      phase_id    <= '0;
      phase_new   <= 1'b0;
      table_full  <= 1'b0;
    end else begin
      phase_valid <= in_v;
      if (in_v) begin
        case (kind)
          RES_HIT: begin
            phase_id   <= hidx;
            phase_new  <= 1'b0;
            table_full <= 1'b0;
          end
          RES_NEW: begin
            used[nused[IDW-1:0]] <= 1'b1;
            nused      <= nused + 1'b1;
            phase_id   <= nused[IDW-1:0];
            phase_new  <= 1'b1;
            table_full <= 1'b0;
          end
          default: begin
            phase_id   <= '0;
            phase_new  <= 1'b0;
            table_full <= 1'b1;
          end
        endcase
      end
    end
  end

  // R5: not every bucket can be strictly above the mean
  assert_sig_not_all_R5: assert property (@(posedge clk) disable iff (rst)
    in_v |-> (sig != '1));
  // R7: a reported hit refers to an entry already in use
  assert_hit_in_use_R7: assert property (@(posedge clk) disable iff (rst)
    (phase_valid && !phase_new && !table_full) |-> ((IDW+1)'(phase_id) < nused));
  // R9: full and new are exclusive
  assert_full_excl_R9: assert property (@(posedge clk) disable iff (rst)
    phase_valid |-> !(phase_new && table_full));
  // R9: a full miss reports index zero
  assert_full_id_R9: assert property (@(posedge clk) disable iff (rst)
    (phase_valid && table_full) |-> (phase_id == '0));
  // R10: result held between pulses
  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !phase_valid |-> ($stable(phase_id) && $stable(phase_new) && $stable(table_full)));
endmodule

// File: rtl/phase_sig_detector.sv
module phase_sig_detector #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int LEN_W  = 32,
  parameter int NBKT   = 32,
  parameter int BKT_W  = 24,
  parameter int NHIST  = 16,
  localparam int HB    = $clog2(NBKT),
  localparam int SUM_W = BKT_W + HB,
  localparam int HD_W  = $clog2(NBKT + 1),
  localparam int IDW   = $clog2(NHIST)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              br_valid,
  input  logic [ADDR_W-1:0] br_addr,
  input  logic [CNT_W-1:0]  br_icount,
  input  logic [LEN_W-1:0]  cfg_interval_len,
  input  logic [HD_W-1:0]   cfg_hd_thresh,
  output logic              phase_valid,
  output logic [IDW-1:0]    phase_id,
  output logic              phase_new,
  output logic              table_full
);
  logic                  snap_v;
  logic [NBKT*BKT_W-1:0] snap_flat;
  logic [SUM_W-1:0]      snap_sum;

  phase_accum #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LEN_W(LEN_W), .NBKT(NBKT), .BKT_W(BKT_W)
  ) u_accum (
    .clk(clk), .rst(rst), .br_valid(br_valid), .br_addr(br_addr),
    .br_icount(br_icount), .cfg_len(cfg_interval_len),
    .snap_v(snap_v), .snap_flat(snap_flat), .snap_sum(snap_sum)
  );

  phase_match #(.NBKT(NBKT), .BKT_W(BKT_W), .NHIST(NHIST)) u_match (
    .clk(clk), .rst(rst), .in_v(snap_v), .snap_flat(snap_flat),
    .snap_sum(snap_sum), .cfg_thresh(cfg_hd_thresh),
    .phase_valid(phase_valid), .phase_id(phase_id),
    .phase_new(phase_new), .table_full(table_full)
  );
endmodule

// File: tb/phase_sig_detector_tb.sv
`timescale 1ns/1ps
module phase_sig_detector_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        br_valid = 1'b0;
  logic [31:0] br_addr = '0;
  logic [15:0] br_icount = '0;
  logic [31:0] cfg_interval_len = 32'd4;
  logic [5:0]  cfg_hd_thresh = '0;
  logic        phase_valid;
  logic [3:0]  phase_id;
  logic        phase_new;
  logic        table_full;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  phase_sig_detector #(.BKT_W(8)) u_dut (
    .clk(clk), .rst(rst), .br_valid(br_valid), .br_addr(br_addr),
    .br_icount(br_icount), .cfg_interval_len(cfg_interval_len),
    .cfg_hd_thresh(cfg_hd_thresh), .phase_valid(phase_valid),
    .phase_id(phase_id), .phase_new(phase_new), .table_full(table_full)
  );

  // {mask, thresh, expected id, expected new}
  localparam logic [42:0] VEC [8] = '{
    {32'h0000000F, 6'd2, 4'd0, 1'b1},
    {32'h0000000F, 6'd2, 4'd0, 1'b0},
    {32'h000000F0, 6'd2, 4'd1, 1'b1},
    {32'h0000001F, 6'd2, 4'd0, 1'b0},
    {32'h00FF0000, 6'd2, 4'd2, 1'b1},
    {32'h000000F1, 6'd2, 4'd1, 1'b0},
    {32'h000000FF, 6'd8, 4'd0, 1'b0},
    {32'h0F000000, 6'd0, 4'd3, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] a, input logic [15:0] c);
    br_valid = 1'b1; br_addr = a; br_icount = c;
    @(negedge clk);
    br_valid = 1'b0;
  endtask

  task automatic expect_res(input int id, input bit nw, input bit fl, input string req);
    @(negedge clk);
    chk(phase_valid == 1'b1, {req, " R6 pulse"}, phase_valid, 1);
    chk(phase_id == id[3:0], {req, " id"}, phase_id, id);
    chk(phase_new == nw, {req, " new"}, phase_new, nw);
    chk(table_full == fl, {req, " full"}, table_full, fl);
    @(negedge clk);
    chk(phase_valid == 1'b0, {req, " R6 one cycle"}, phase_valid, 0);
  endtask

  task automatic feed_mask(input logic [31:0] m);
    cfg_interval_len = 32'd4 * $countones(m);
    for (int b = 0; b < 32; b++) if (m[b]) send(32'(b) << 2, 16'd4);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(phase_valid == 0 && phase_id == 0 && phase_new == 0 && table_full == 0,
        "R1 reset outputs", {phase_valid, phase_id, phase_new, table_full}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(phase_valid == 0 && phase_id == 0, "R1 after release", phase_valid, 0);

    // vector table: R7, R8 lookup and allocation
    for (int v = 0; v < 8; v++) begin
      cfg_hd_thresh = VEC[v][10:5];
      feed_mask(VEC[v][42:11]);
      expect_res(int'(VEC[v][4:1]), VEC[v][0], 1'b0, $sformatf("R7/R8 vec%0d", v));
    end

    // R2: fold cancels bits 12,7,2 -> bucket 1; low bits ignored
    cfg_hd_thresh = 6'd0;
    cfg_interval_len = 32'd8;
    send(32'h0000_0083, 16'd4);
    send(32'h0000_0083, 16'd4);
    expect_res(4, 1'b1, 1'b0, "R2 folded addr new");
    cfg_interval_len = 32'd4;
    send(32'h0000_1084, 16'd4);
    expect_res(4, 1'b0, 1'b0, "R2 fold equivalence");

    // R5: only bucket 0 above mean
    cfg_interval_len = 32'd103;
    send(32'h0, 16'd100);
    send(32'h4, 16'd1);
    send(32'h8, 16'd1);
    send(32'hC, 16'd1);
    expect_res(5, 1'b1, 1'b0, "R5 mean threshold new");
    cfg_interval_len = 32'd4;
    send(32'h0, 16'd4);
    expect_res(5, 1'b0, 1'b0, "R5 single bucket hit");

    // R3: bucket 0 clamps at 255, so buckets 1..8 sit above mean
    cfg_interval_len = 32'd1320;
    for (int i = 0; i < 4; i++) send(32'h0, 16'd250);
    for (int b = 1; b <= 8; b++) send(32'(b) << 2, 16'd40);
    expect_res(6, 1'b1, 1'b0, "R3 saturation new");
    feed_mask(32'h000001FF);
    expect_res(6, 1'b0, 1'b0, "R3 saturated signature hit");

    // R4: close at exactly the length, then clean restart
    cfg_interval_len = 32'd8;
    send(32'(9) << 2, 16'd4);
    @(negedge clk);
    chk(phase_valid == 1'b0, "R4 no early close", phase_valid, 0);
    @(negedge clk);
    chk(phase_valid == 1'b0, "R4 no early close 2", phase_valid, 0);
    send(32'(9) << 2, 16'd4);
    expect_res(7, 1'b1, 1'b0, "R4 close at length");
    cfg_interval_len = 32'd4;
    send(32'(10) << 2, 16'd4);
    expect_res(8, 1'b1, 1'b0, "R4 buckets cleared");

    // R10: hold
    repeat (5) @(negedge clk);
    chk(phase_id == 4'd8 && phase_new == 1'b1 && phase_valid == 1'b0,
        "R10 hold", phase_id, 8);

    // R8 fill, then R9 full
    for (int k = 0; k < 7; k++) begin
      feed_mask(32'h1 << (20 + k));
      expect_res(9 + k, 1'b1, 1'b0, "R8 fill");
    end
    feed_mask(32'h1000_0000);
    expect_res(0, 1'b0, 1'b1, "R9 table full");
    feed_mask(32'h1000_0000);
    expect_res(0, 1'b0, 1'b1, "R9 table unchanged");
    feed_mask(32'h0000000F);
    expect_res(0, 1'b0, 1'b0, "R9 hit after full");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule